// File: doc/BRIEF.md
# Keyed Bridge Configuration Register

A single 32-bit control register for a bus bridge controller. Software reaches it through a plain register port with a write strobe, a read strobe, write data and combinational read data. A write changes the register only if the top byte of the write data holds the unlock key 8'hA5. Any other top byte leaves every bit as it was. The key is never stored.

The register has two reset sources. The power-on reset (`rst_ni`, asynchronous, active low) clears every writable bit. While it is held, the clock keeps running and the register copies the two mode pins on every edge. The last copy becomes a read-only mode field. The software reset (`sw_rst_i`, synchronous) clears the same writable bits with one exception: the reset-control bit keeps its value. The software reset also keeps the mode field that was captured at power-on; it does not sample the pins again.

The register drives five controls:
- read-buffer mode (one buffer or two buffers with read-ahead);
- programmed-I/O byte swap;
- pull-up disable;
- a spare control bit;
- the init-complete flag.

It also drives the reset-control bit and the mode field. The buffers, the swap datapath and the pads are outside this block.

Top module: `bridge_cfg_reg`

## Requirements
- R1: A write with wdata_i[31:24] == 8'hA5 loads the writable bits in the next cycle. The writable bits are 9 (single read buffer), 8 (byte swap), 7 (pull-up disable), 6 (spare), 1 (reset control) and 0 (init done). The loaded values are the matching wdata_i bits.
- R2: A write whose wdata_i[31:24] is not 8'hA5 leaves all 32 read bits unchanged.
- R3: Read bits 31..10 and bits 3..2 are always zero. This includes the key byte, which is never stored.
- R4: After power-on reset, bits 9..6, 1 and 0 read 0. Bits 5..4 read the mode_pins_i level sampled at the last clock edge while rst_ni was low (pin 1 to bit 5, pin 0 to bit 4).
- R5: After power-on reset, bits 5..4 and mode_o stay fixed. This holds when the pins change, when a keyed write carries other values, and through a software reset.
- R6: A software reset clears bits 9..6 and 0 in the next cycle and leaves bit 1 unchanged.
- R7: Power-on reset overrides software reset, and software reset overrides a keyed write in the same cycle.
- R8: The outputs follow the stored bits: rd_single_buf_o = bit 9 (1 selects a single 32-byte buffer, 0 selects two with read-ahead), byte_swap_o = bit 8, pullup_dis_o = bit 7 (0 means pull-ups on), spare_o = bit 6, rst_ctl_o = bit 1, init_done_o = bit 0, mode_o = bits 5..4.
- R9: ready_o is 1 exactly in the cycle after a cycle with wr_en_i or rd_en_i high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| sw_rst_i | input | 1 | Software reset, synchronous, active high |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data; bits 31..24 carry the key |
| rdata_o | output | 32 | Register contents, combinational |
| ready_o | output | 1 | Access response, one cycle after a strobe |
| mode_pins_i | input | 2 | Mode pins, sampled during power-on reset |
| rd_single_buf_o | output | 1 | 1: one read buffer; 0: two buffers with read-ahead |
| byte_swap_o | output | 1 | Byte swap for programmed-I/O data |
| pullup_dis_o | output | 1 | 1 turns the signal pull-ups off |
| spare_o | output | 1 | Spare control bit |
| rst_ctl_o | output | 1 | Reset-control bit, kept through software reset |
| init_done_o | output | 1 | Init-complete flag |
| mode_o | output | 2 | Mode field captured at power-on |

## Verification
Keyed writes are tried with all-ones, all-zeros and alternating data. These patterns separate a bit that is really writable from one stuck at its reset value, and they show whether the reserved and mode bits leak through. The same patterns are sent with wrong keys that differ from 8'hA5 in a single bit, with 8'h00, and with the key moved to another byte. These show whether the whole key byte is compared. Two power-on resets with opposite pin levels, followed by pin toggling, show whether the mode field is sampled or wired straight through. Software resets are applied with bit 1 both set and clear, and together with keyed writes, to show that bit 1 is kept and that the reset wins over a write in the same cycle.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned KEY_W     = 8;
  localparam int unsigned KEY_LSB   = DATA_W - KEY_W;
  localparam logic [KEY_W-1:0] KEY  = 8'hA5;
  localparam int unsigned MODE_W    = 2;

  localparam int unsigned B_SGL     = 9;
  localparam int unsigned B_SWAP    = 8;
  localparam int unsigned B_PUDIS   = 7;
  localparam int unsigned B_SPARE   = 6;
  localparam int unsigned B_MODE_LO = 4;
  localparam int unsigned B_RSTCTL  = 1;
  localparam int unsigned B_DONE    = 0;

  typedef struct packed {
    logic sgl;
    logic swap;
    logic pudis;
    logic spare;
    logic rstctl;
    logic done;
  } ctl_t;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SWRST = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bridge_cfg_key_gate.sv
module bridge_cfg_key_gate
  import bridge_cfg_pkg::*;
(
  input  logic              wr_en_i,
  input  logic              sw_rst_i,
  input  logic [DATA_W-1:0] wdata_i,
  output op_e               op_o
);
  logic key_ok;
  assign key_ok = (wdata_i[DATA_W-1:KEY_LSB] == KEY);

  // software reset outranks any write
  always_comb begin
    if (sw_rst_i)              op_o = OP_SWRST;
    else if (wr_en_i && key_ok) op_o = OP_WRITE;
    else                       op_o = OP_HOLD;
  end
endmodule

// File: rtl/bridge_cfg_mode_latch.sv
module bridge_cfg_mode_latch
  import bridge_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] pins_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;

  // tracks the pins while power-on reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= pins_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bridge_cfg_ctl_core.sv
module bridge_cfg_ctl_core
  import bridge_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              req_i,
  output ctl_t              ctl_o,
  output logic              ready_o
);
  ctl_t ctl_q, ctl_d, wr_val;

  always_comb begin
    wr_val.sgl    = wdata_i[B_SGL];
    wr_val.swap   = wdata_i[B_SWAP];
    wr_val.pudis  = wdata_i[B_PUDIS];
    wr_val.spare  = wdata_i[B_SPARE];
    wr_val.rstctl = wdata_i[B_RSTCTL];
    wr_val.done   = wdata_i[B_DONE];
  end

  always_comb begin
    ctl_d = ctl_q;
    unique case (op_i)
      OP_SWRST: begin
        ctl_d        = '0;
        ctl_d.rstctl = ctl_q.rstctl;
      end
      OP_WRITE: ctl_d = wr_val;
      default:  ctl_d = ctl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      ready_o <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      ready_o <= req_i;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/bridge_cfg_reg.sv
module bridge_cfg_reg
  import bridge_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  input  logic [MODE_W-1:0] mode_pins_i,
  output logic              rd_single_buf_o,
  output logic              byte_swap_o,
  output logic              pullup_dis_o,
  output logic              spare_o,
  output logic              rst_ctl_o,
  output logic              init_done_o,
  output logic [MODE_W-1:0] mode_o
);
  op_e               op;
  ctl_t              ctl;
  logic [MODE_W-1:0] mode;

  bridge_cfg_key_gate u_gate (
    .wr_en_i (wr_en_i),
    .sw_rst_i(sw_rst_i),
    .wdata_i (wdata_i),
    .op_o    (op)
  );

  bridge_cfg_mode_latch u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(mode_pins_i),
    .mode_o(mode)
  );

  bridge_cfg_ctl_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .wdata_i(wdata_i),
    .req_i  (wr_en_i | rd_en_i),
    .ctl_o  (ctl),
    .ready_o(ready_o)
  );

  always_comb begin
    rdata_o                                = '0;
    rdata_o[B_SGL]                         = ctl.sgl;
    rdata_o[B_SWAP]                        = ctl.swap;
    rdata_o[B_PUDIS]                       = ctl.pudis;
    rdata_o[B_SPARE]                       = ctl.spare;
    rdata_o[B_MODE_LO+MODE_W-1:B_MODE_LO]  = mode;
    rdata_o[B_RSTCTL]                      = ctl.rstctl;
    rdata_o[B_DONE]                        = ctl.done;
  end

  assign rd_single_buf_o = ctl.sgl;
  assign byte_swap_o     = ctl.swap;
  assign pullup_dis_o    = ctl.pudis;
  assign spare_o         = ctl.spare;
  assign rst_ctl_o       = ctl.rstctl;
  assign init_done_o     = ctl.done;
  assign mode_o          = mode;
endmodule

// File: rtl/bridge_cfg_reg_chk.sv
module bridge_cfg_reg_chk
  import bridge_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_rst_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ready_o,
  input logic [MODE_W-1:0] mode_o
);
  a_r1_key_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sw_rst_i && wdata_i[DATA_W-1:KEY_LSB] == KEY) |=>
      (rdata_o[9:6] == $past(wdata_i[9:6]) && rdata_o[1:0] == $past(wdata_i[1:0])));

  a_r2_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sw_rst_i && wdata_i[DATA_W-1:KEY_LSB] != KEY) |=> $stable(rdata_o));

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DATA_W-1:10] == '0 && rdata_o[3:2] == 2'b00));

  a_r5_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mode_o));

  a_r6_sw_keep_rstctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (rdata_o[B_RSTCTL] == $past(rdata_o[B_RSTCTL]) &&
                  rdata_o[9:6] == 4'b0 && rdata_o[B_DONE] == 1'b0));

  a_r9_ready_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || rd_en_i) |=> ready_o);

  a_r9_ready_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i || rd_en_i) |=> !ready_o);
endmodule

bind bridge_cfg_reg bridge_cfg_reg_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sw_rst_i(sw_rst_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ready_o (ready_o),
  .mode_o  (mode_o)
);

// File: tb/tb_bridge_cfg_reg.sv
module tb_bridge_cfg_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o;
  logic [1:0]  mode_pins_i = 2'b10;
  logic        rd_single_buf_o, byte_swap_o, pullup_dis_o, spare_o;
  logic        rst_ctl_o, init_done_o;
  logic [1:0]  mode_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_reg = '0;
  logic        m_rdy = 1'b0;
  logic        m_valid = 1'b0;

  always #10 clk_i = ~clk_i;

  bridge_cfg_reg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_rst_i(sw_rst_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ready_o(ready_o), .mode_pins_i(mode_pins_i),
    .rd_single_buf_o(rd_single_buf_o), .byte_swap_o(byte_swap_o),
    .pullup_dis_o(pullup_dis_o), .spare_o(spare_o), .rst_ctl_o(rst_ctl_o),
    .init_done_o(init_done_o), .mode_o(mode_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg[9:6] <= '0;
      m_reg[1:0] <= '0;
      m_rdy      <= 1'b0;
      if (clk_i) begin
        m_reg[5:4] <= mode_pins_i;
        m_valid    <= 1'b1;
      end
    end else begin
      m_rdy <= wr_en_i | rd_en_i;
      if (sw_rst_i) begin
        m_reg[9:6] <= '0;
        m_reg[0]   <= 1'b0;
      end else if (wr_en_i && wdata_i[31:24] == 8'hA5) begin
        m_reg[9:6] <= wdata_i[9:6];
        m_reg[1:0] <= wdata_i[1:0];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (m_valid) begin
      chk("R1 rdata", rdata_o, m_reg);
      chk("R8 outputs",
          {26'd0, rd_single_buf_o, byte_swap_o, pullup_dis_o, spare_o, rst_ctl_o, init_done_o},
          {26'd0, m_reg[9], m_reg[8], m_reg[7], m_reg[6], m_reg[1], m_reg[0]});
      chk("R8 mode_o", {30'd0, mode_o}, {30'd0, m_reg[5:4]});
      chk("R9 ready", {31'd0, ready_o}, {31'd0, m_rdy});
    end
  end

  task automatic cyc(input logic sw, input logic wr, input logic rd, input logic [31:0] d);
    sw_rst_i = sw; wr_en_i = wr; rd_en_i = rd; wdata_i = d;
    @(negedge clk_i);
    sw_rst_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic por(input logic [1:0] pins);
    rst_ni = 1'b0;
    mode_pins_i = pins;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    @(negedge clk_i);
    por(2'b10);
    chk("R4 por value", rdata_o, 32'h0000_0020);
    chk("R9 ready idle", {31'd0, ready_o}, 32'd0);

    cyc(0, 1, 0, 32'hA5FF_FFFF);
    chk("R1 all ones", rdata_o, 32'h0000_03E3);
    chk("R3 reserved zero", rdata_o & 32'hFFFF_FC0C, 32'd0);
    chk("R9 ready after write", {31'd0, ready_o}, 32'd1);
    chk("R8 single buf", {31'd0, rd_single_buf_o}, 32'd1);

    cyc(0, 1, 0, 32'hA500_0000);
    chk("R1 all zeros", rdata_o, 32'h0000_0020);
    cyc(0, 1, 0, 32'hA500_0155);
    chk("R1 alternating", rdata_o, 32'h0000_0161);
    cyc(0, 1, 0, 32'hA500_02AA);
    chk("R1 alternating inv", rdata_o, 32'h0000_02A2);

    snap = rdata_o;
    cyc(0, 1, 0, 32'hA4FF_FFFF);
    chk("R2 key bit0 wrong", rdata_o, snap);
    cyc(0, 1, 0, 32'h25FF_FFFF);
    chk("R2 key bit7 wrong", rdata_o, snap);
    cyc(0, 1, 0, 32'h0000_0000);
    chk("R2 key zero", rdata_o, snap);
    cyc(0, 1, 0, 32'h00A5_03C3);
    chk("R2 key misplaced", rdata_o, snap);
    cyc(0, 0, 1, 32'hA5FF_FFFF);
    chk("R2 read no write", rdata_o, snap);
    chk("R9 ready after read", {31'd0, ready_o}, 32'd1);

    mode_pins_i = 2'b01;
    cyc(0, 1, 0, 32'hA500_0010);
    chk("R5 mode held", {30'd0, mode_o}, {30'd0, 2'b10});

    cyc(0, 1, 0, 32'hA500_03C3);
    cyc(1, 0, 0, 32'h0);
    chk("R6 sw reset keeps bit1", rdata_o, 32'h0000_0022);
    cyc(0, 1, 0, 32'hA500_03C1);
    cyc(1, 0, 0, 32'h0);
    chk("R6 sw reset bit1 low", rdata_o, 32'h0000_0020);
    chk("R5 mode after sw reset", {30'd0, mode_o}, {30'd0, 2'b10});

    cyc(0, 1, 0, 32'hA500_0002);
    cyc(1, 1, 0, 32'hA500_03C1);
    chk("R7 sw over write", rdata_o, 32'h0000_0022);

    cyc(0, 1, 0, 32'hA500_03C3);
    sw_rst_i = 1'b1; wr_en_i = 1'b1; wdata_i = 32'hA500_03C3;
    por(2'b01);
    sw_rst_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
    @(negedge clk_i);
    chk("R7 por over all", rdata_o, 32'h0000_0010);
    chk("R4 second por pins", {30'd0, mode_o}, {30'd0, 2'b01});

    mode_pins_i = 2'b11;
    repeat (3) @(negedge clk_i);
    chk("R5 pins toggled", {30'd0, mode_o}, {30'd0, 2'b01});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule